// File: doc/BRIEF.md
# Keyed Watchdog Countdown Timer

This block is a watchdog that software must keep servicing. It has a small bank of 32-bit registers addressed by byte offset. Firmware loads a reload value and sets the enable bit. After that it has to write a restart key often enough that the down-counter never runs out. The counter advances on one of two time bases, picked by a control bit: every system clock, or a 1 MHz tick made by an internal prescaler.

When the final tick arrives, the block raises a one-cycle reset request and stops. The one exception is an external flag that reports a memory-controller reset. If that flag is high at expiry, the block disables itself instead of asking for a reset. Software can also fire the reset request at once by writing a second, 32-bit key while the control word selects the chip-internal reset mode.

The bus is a single-cycle request. Writes take effect at the clock edge that samples them. Read data is registered and appears on the cycle after the request.

Top module: `wdog_countdown`

## Requirements
- R1: After reset, the count register (offset 0x00) and the reload register (offset 0x04) both read 0x014FB180, the control register (offset 0x0C) reads 0, and `rst_req` is low.
- R2: The count register is read-only and shows the live counter. The reload and control registers read back what was written. A read of the restart offset 0x08, of any other offset, or of an address whose two low bits are not zero returns 0. A write to 0x00 or to a misaligned address changes nothing.
- R3: A write to offset 0x08 whose low 16 bits equal 0x4755 loads the counter from the reload register, whatever the upper 16 bits hold. If control bit 0 is set, counting restarts. A write of any other value to 0x08 is ignored.
- R4: A control write that takes bit 0 from 0 to 1 loads the counter from the reload register and starts counting. A write that takes bit 0 from 1 to 0 freezes the counter at its present value. A control write that leaves bit 0 unchanged only updates the stored control word.
- R5: When control bit 4 is 1, the counter steps once every SYS_CLK_HZ/TICK_HZ clocks, and the prescaler phase restarts at every restart or enable. When bit 4 is 0, it steps on every clock. Let D be the step period in clocks. A reload value N of 1 or more expires at the D·N-th clock edge after the start edge. A reload value of 0 expires at the D-th edge.
- R6: At expiry, `rst_req` is high for exactly one cycle, in the cycle after the final tick. The counter stops and reads 0.
- R7: If `mem_rst_flag` is high at expiry, `rst_req` stays low, the control register is cleared to 0, and counting stops. A later restart key does not start it again.
- R8: A write of exactly 0xAEEDF123 to offset 0x24 while control bits 6:5 are 00 raises `rst_req` for one cycle after the write edge. Any other value, or any other mode, has no effect.
- R9: A restart key written in the same cycle as the final tick wins: the counter reloads and no request is raised. A disabling control write in the same cycle as a tick freezes the counter without stepping it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| mem_rst_flag | input | 1 | Memory-controller reset in progress; suppresses expiry |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bus path and the countdown can act in the same clock edge. The case that matters is a restart key or a disabling control write that lands on the exact edge of the final tick. The bench computes that edge from the reload value and the step period. It places the key write on that edge, then checks two things: no request is raised, and a fresh full countdown follows. It does the same with a disable write, then reads back a count that has not stepped. A software-reset write against a stopped counter checks the second trigger of the shared request register on its own.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int WORD_W = 32;

  // register byte offsets
  localparam logic [7:0] OFS_COUNT  = 8'h00;
  localparam logic [7:0] OFS_RELOAD = 8'h04;
  localparam logic [7:0] OFS_KICK   = 8'h08;
  localparam logic [7:0] OFS_CTRL   = 8'h0C;
  localparam logic [7:0] OFS_SWRST  = 8'h24;

  // service keys
  localparam logic [15:0]       KICK_KEY  = 16'h4755;
  localparam logic [WORD_W-1:0] SWRST_KEY = 32'hAEEDF123;

  // control word fields
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_TSEL_BIT  = 4;
  localparam int CTRL_MODE_LSB  = 5;
  localparam int CTRL_MODE_W    = 2;

  // single-cycle events decoded from the bus
  typedef struct packed {
    logic kick;
    logic en_rise;
    logic en_fall;
    logic swrst;
  } wdog_evt_t;

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_passthru
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          pre_q <= '0;
        end else if (pre_q == LAST) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end

      assign tick = (pre_q == LAST);

      // R5: ticks are separated by at least one idle clock
      p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int               ADDR_W      = 8,
  parameter logic [WORD_W-1:0] RESET_COUNT = 32'h014FB180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] live_count,
  input  logic              clear_ctrl,
  output logic [WORD_W-1:0] reload_q,
  output logic              en_q,
  output logic              tsel_q,
  output wdog_evt_t         evt,
  output logic [WORD_W-1:0] rdata_q
);

  logic [WORD_W-1:0] ctrl_q;
  logic              aligned, wr, rd;
  logic              hit_count, hit_reload, hit_kick, hit_ctrl, hit_swrst;
  logic              ctrl_wr, reload_wr;
  logic              soc_mode;
  logic [WORD_W-1:0] rd_mux;

  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign wr         = bus_req &  bus_we & aligned;
  assign rd         = bus_req & ~bus_we & aligned;

  assign hit_count  = (bus_addr == ADDR_W'(OFS_COUNT));
  assign hit_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
  assign hit_kick   = (bus_addr == ADDR_W'(OFS_KICK));
  assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_swrst  = (bus_addr == ADDR_W'(OFS_SWRST));

  assign ctrl_wr    = wr & hit_ctrl;
  assign reload_wr  = wr & hit_reload;
  assign soc_mode   = (ctrl_q[CTRL_MODE_LSB +: CTRL_MODE_W] == '0);

  always_comb begin
    evt.kick    = wr & hit_kick & (bus_wdata[15:0] == KICK_KEY);
    evt.en_rise = ctrl_wr &  bus_wdata[CTRL_EN_BIT] & ~ctrl_q[CTRL_EN_BIT];
    evt.en_fall = ctrl_wr & ~bus_wdata[CTRL_EN_BIT] &  ctrl_q[CTRL_EN_BIT];
    evt.swrst   = wr & hit_swrst & (bus_wdata == SWRST_KEY) & soc_mode;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_count)       rd_mux = live_count;
    else if (hit_reload) rd_mux = reload_q;
    else if (hit_ctrl)   rd_mux = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= RESET_COUNT;
      ctrl_q   <= '0;
      rdata_q  <= '0;
    end else begin
      if (reload_wr) reload_q <= bus_wdata;
      if (ctrl_wr) begin
        ctrl_q <= bus_wdata;
      end else if (clear_ctrl) begin
        ctrl_q <= '0;
      end
      rdata_q <= rd ? rd_mux : '0;
    end
  end

  assign en_q   = ctrl_q[CTRL_EN_BIT];
  assign tsel_q = ctrl_q[CTRL_TSEL_BIT];

  // R2: reload only moves on an aligned write to its offset
  p_reload_kept_r2: assert property (@(posedge clk) disable iff (rst)
    !reload_wr |=> $stable(reload_q));

  // R7: a memory-reset expiry leaves the control word at zero
  p_ctrl_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    (clear_ctrl && !ctrl_wr) |=> (ctrl_q == '0));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_COUNT = 32'h014FB180
) (
  input  logic              clk,
  input  logic              rst,
  input  wdog_evt_t         evt,
  input  logic [WORD_W-1:0] reload,
  input  logic              en,
  input  logic              tsel,
  input  logic              tick_slow,
  input  logic              mem_flag,
  output logic [WORD_W-1:0] count_q,
  output logic              clear_ctrl,
  output logic              rst_req_q
);

  logic running_q;
  logic step;
  logic final_tick;
  logic expire;

  assign step       = tsel ? tick_slow : 1'b1;
  assign final_tick = running_q & step & (count_q <= WORD_W'(1));
  // bus events on the same edge take precedence over the last tick
  assign expire     = final_tick & ~evt.kick & ~evt.en_fall;
  assign clear_ctrl = expire & mem_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= RESET_COUNT;
      running_q <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= (expire & ~mem_flag) | evt.swrst;
      if (evt.kick) begin
        count_q   <= reload;
        running_q <= en;
      end else if (evt.en_rise) begin
        count_q   <= reload;
        running_q <= 1'b1;
      end else if (evt.en_fall) begin
        running_q <= 1'b0;
      end else if (running_q && step) begin
        if (count_q <= WORD_W'(1)) begin
          count_q   <= '0;
          running_q <= 1'b0;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end

  // R3: a valid key loads the reload value
  p_kick_load_r3: assert property (@(posedge clk) disable iff (rst)
    evt.kick |=> (count_q == $past(reload)));

  // R4: a stopped counter holds its value
  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!running_q && !evt.kick && !evt.en_rise) |=> $stable(count_q));

  // R5: each tick lowers the count by one
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (running_q && step && count_q > WORD_W'(1) && !evt.kick && !evt.en_fall)
      |=> (count_q == $past(count_q) - 1'b1));

  // R6: a normal expiry yields the request and a halted zero count
  p_expire_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && !mem_flag) |=> (rst_req_q && !running_q && count_q == '0));

  // R7: memory-reset flag suppresses the request
  p_mem_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (expire && mem_flag && !evt.swrst) |=> (!rst_req_q && !running_q));

  // R9: a key on the final tick edge leaves the counter running
  p_kick_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (final_tick && evt.kick && en && !evt.swrst) |=> (!rst_req_q && running_q));

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int               ADDR_W      = 8,
  parameter int               SYS_CLK_HZ  = 50_000_000,
  parameter int               TICK_HZ     = 1_000_000,
  parameter logic [WORD_W-1:0] RESET_COUNT = 32'h014FB180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              mem_rst_flag,
  output logic              rst_req
);

  localparam int DIV = (SYS_CLK_HZ / TICK_HZ < 1) ? 1 : SYS_CLK_HZ / TICK_HZ;

  wdog_evt_t         evt;
  logic [WORD_W-1:0] reload;
  logic [WORD_W-1:0] count;
  logic              en, tsel, clear_ctrl, tick_slow;

  wdog_regs #(
    .ADDR_W      (ADDR_W),
    .RESET_COUNT (RESET_COUNT)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .live_count (count),
    .clear_ctrl (clear_ctrl),
    .reload_q   (reload),
    .en_q       (en),
    .tsel_q     (tsel),
    .evt        (evt),
    .rdata_q    (bus_rdata)
  );

  wdog_tick_gen #(
    .DIV (DIV)
  ) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (evt.kick | evt.en_rise),
    .tick (tick_slow)
  );

  wdog_core #(
    .RESET_COUNT (RESET_COUNT)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .reload     (reload),
    .en         (en),
    .tsel       (tsel),
    .tick_slow  (tick_slow),
    .mem_flag   (mem_rst_flag),
    .count_q    (count),
    .clear_ctrl (clear_ctrl),
    .rst_req_q  (rst_req)
  );

endmodule

// File: tb/wdog_countdown_tb.sv
`timescale 1ns/1ps
module wdog_countdown_tb;

  localparam int DIV = 4;
  localparam logic [31:0] RST_VAL = 32'h014FB180;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mem_rst_flag = 1'b0;
  logic        rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_countdown #(
    .ADDR_W     (8),
    .SYS_CLK_HZ (DIV * 1_000_000),
    .TICK_HZ    (1_000_000)
  ) u_dut (
    .clk          (clk),
    .rst          (rst),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .mem_rst_flag (mem_rst_flag),
    .rst_req      (rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp_v);
    end
  endtask

  // all bus tasks start just after a falling edge; the access is taken at the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // request must appear only after the at-th rising edge counted from now
  task automatic pulse_at(input string tag, input int at, input int span);
    for (int k = 1; k <= span; k++) begin
      @(negedge clk);
      chk(tag, {31'd0, rst_req}, {31'd0, (k == at)});
    end
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
    rd(8'h00, v); chk("R1 count", v, RST_VAL);
    rd(8'h04, v); chk("R1 reload", v, RST_VAL);
    rd(8'h0C, v); chk("R1 ctrl", v, 32'd0);

    // R2 decode, zero reads, ignored writes
    rd(8'h08, v); chk("R2 kick reads 0", v, 32'd0);
    rd(8'h10, v); chk("R2 unused 0x10", v, 32'd0);
    rd(8'h24, v); chk("R2 swrst reads 0", v, 32'd0);
    rd(8'h3C, v); chk("R2 unused 0x3C", v, 32'd0);
    rd(8'h05, v); chk("R2 misaligned read", v, 32'd0);
    wr(8'h00, 32'h1234); rd(8'h00, v); chk("R2 count read-only", v, RST_VAL);
    wr(8'h06, 32'h77);   rd(8'h04, v); chk("R2 misaligned write", v, RST_VAL);
    wr(8'h04, 32'h55);   rd(8'h04, v); chk("R2 reload rw", v, 32'h55);
    wr(8'h0C, 32'h60);   rd(8'h0C, v); chk("R2 ctrl rw", v, 32'h60);
    wr(8'h0C, 32'h0);

    // R5 / R6 expiry timing sweep over both time bases
    for (int t = 0; t < 2; t++) begin
      for (int n = 0; n <= 5; n++) begin
        int d;
        d = (t == 1) ? DIV : 1;
        wr(8'h0C, {27'd0, t[0], 4'd0});
        wr(8'h04, n);
        wr(8'h0C, {27'd0, t[0], 4'd1});
        pulse_at($sformatf("R5 R6 tsel=%0d n=%0d", t, n), d * ((n == 0) ? 1 : n), d * ((n == 0) ? 1 : n) + 2);
      end
    end
    rd(8'h00, v); chk("R6 count zero after expiry", v, 32'd0);

    // R3 valid key with upper bits set restarts the countdown
    wr(8'h0C, 32'h0); wr(8'h04, 32'd8); wr(8'h0C, 32'h1);
    idle(3);
    wr(8'h08, 32'hFFFF4755);
    pulse_at("R3 key restart", 8, 10);

    // R3 wrong key ignored: original expiry stands
    wr(8'h0C, 32'h0); wr(8'h0C, 32'h1);
    idle(2);
    wr(8'h08, 32'h00004756);
    pulse_at("R3 bad key ignored", 5, 7);

    // R3 key while disabled loads but does not run
    wr(8'h0C, 32'h0); wr(8'h04, 32'h20); wr(8'h08, 32'h4755);
    idle(5);
    rd(8'h00, v); chk("R3 key while disabled", v, 32'h20);
    chk("R3 no request while disabled", {31'd0, rst_req}, 32'd0);

    // R4 unchanged enable leaves countdown alone
    wr(8'h04, 32'd6); wr(8'h0C, 32'h1);
    idle(2);
    wr(8'h0C, 32'h21);
    pulse_at("R4 unchanged enable", 3, 5);

    // R4 / R9 disable on a tick edge freezes without stepping
    wr(8'h0C, 32'h0); wr(8'h04, 32'd10); wr(8'h0C, 32'h1);
    idle(3);
    wr(8'h0C, 32'h0);
    rd(8'h00, v); chk("R4 R9 frozen count", v, 32'd7);
    idle(4);
    rd(8'h00, v); chk("R4 stays frozen", v, 32'd7);

    // R9 key on the final tick edge wins
    wr(8'h04, 32'd5); wr(8'h0C, 32'h1);
    idle(4);
    wr(8'h08, 32'h4755);
    chk("R9 no request on collision", {31'd0, rst_req}, 32'd0);
    pulse_at("R9 fresh countdown", 5, 7);

    // R7 memory-reset flag suppresses expiry and clears control
    wr(8'h0C, 32'h0); wr(8'h04, 32'd3);
    mem_rst_flag = 1'b1;
    wr(8'h0C, 32'h1);
    pulse_at("R7 no request", 0, 6);
    mem_rst_flag = 1'b0;
    rd(8'h0C, v); chk("R7 ctrl cleared", v, 32'd0);
    rd(8'h00, v); chk("R7 count stopped", v, 32'd0);
    wr(8'h08, 32'h4755);
    pulse_at("R7 stays disabled", 0, 6);

    // R8 software reset key
    wr(8'h0C, 32'h0);
    wr(8'h24, 32'hAEEDF123);
    chk("R8 key fires", {31'd0, rst_req}, 32'd1);
    idle(1);
    chk("R8 one cycle", {31'd0, rst_req}, 32'd0);
    wr(8'h24, 32'hAEEDF124);
    pulse_at("R8 wrong key", 0, 2);
    wr(8'h0C, 32'h20);
    wr(8'h24, 32'hAEEDF123);
    pulse_at("R8 mode 1 blocked", 0, 2);
    wr(8'h0C, 32'h40);
    wr(8'h24, 32'hAEEDF123);
    pulse_at("R8 mode 2 blocked", 0, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule